// File: doc/BRIEF.md
# Fast blank soft mixer

The block crossfades two pixel streams, each of three 8-bit components, under control of a 6-bit fast blank key. Stream A comes from the digitized analog RGB/YUV path. Stream B is the digital YUV input. The blend weight is not supplied directly. Each valid sample derives it from the key, an offset field and an amplitude field, as a signed ramp centred on half weight and limited to the range 0 to 32.

Several controls act on the key before the weight is derived. A clamp control holds the key at mid level. A polarity control reflects the key. A short delay line lets the key trail the video by one or two samples, which gives shadowed characters over a black background. Two override bits pass one source through unmixed. The datapath is a fixed two-stage pipeline, and a valid strobe travels with the data.

Top module: `fb_soft_mixer`

## Requirements
- R1: While rst_n is low, out_valid is 0. Reset also clears the key delay history to zero, so after reset a delayed key reads 0 until enough valid samples have arrived.
- R2: out_valid equals in_valid from two clock cycles earlier, in every mode. out_pix updates only for a valid sample.
- R3: In mixing mode each component i (bits 8i+7..8i of the pixel buses) is (A·(32−M) + B·M + 16) >> 5, saturated to 255, where A is ana_pix and B is dig_pix.
- R4: The weight is M = floor((K − cfg_offset) × cfg_amp / 2) + 16, computed signed with floor toward minus infinity. M is then limited to 0..32. K is the effective key after R5, R6 and R7.
- R5: When cfg_clamp is 1, K is 31 whatever the key sample is, and polarity has no effect.
- R6: When cfg_invert is 1 and cfg_clamp is 0, K is 63 minus the selected key.
- R7: cfg_fb_delay selects which key feeds the sample. 0 means the current fb_level. 1 means the fb_level of the previous valid sample. 2 or 3 means the key from two valid samples earlier. The delay history advances only on valid samples.
- R8: When cfg_pass_dig is 1, out_pix equals dig_pix, whatever cfg_pass_ana is.
- R9: When cfg_pass_dig is 0 and cfg_pass_ana is 1, out_pix equals ana_pix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| ana_pix | input | 24 | Analog-path pixel, three 8-bit components |
| dig_pix | input | 24 | Digital YUV pixel, three 8-bit components |
| fb_level | input | 6 | Fast blank key sample, 0..63 |
| cfg_offset | input | 6 | Key offset, unsigned |
| cfg_amp | input | 4 | Ramp amplitude, unsigned |
| cfg_clamp | input | 1 | Force key to 31 |
| cfg_invert | input | 1 | Reflect key polarity |
| cfg_fb_delay | input | 2 | Key delay in valid samples (0, 1, 2; 3 acts as 2) |
| cfg_pass_dig | input | 1 | Pass digital stream unmixed (priority) |
| cfg_pass_ana | input | 1 | Pass analog stream unmixed |
| out_valid | output | 1 | Output sample strobe |
| out_pix | output | 24 | Mixed pixel |

## Verification
The bench targets the negative half of the ramp. A key one step below the offset with amplitude 1 must give weight 15; a design that rounds toward zero gives 16 instead. The extreme keys with full amplitude must drive the weight to 0 and to 32. A design that wraps instead of limiting would output the wrong source. The bench also holds the delay at two across a reset, where stale history would show up as a wrong weight. It checks that the clamp overrides polarity, and that digital pass-through wins when both pass bits are set.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  localparam int unsigned WT_BITS = 5;
  localparam int unsigned WT_FULL = 1 << WT_BITS;
  localparam int unsigned WT_MID  = WT_FULL / 2;
  localparam int unsigned WT_W    = WT_BITS + 1;
  typedef logic [WT_W-1:0] weight_t;
endpackage

// File: rtl/fbm_key_delay.sv
module fbm_key_delay #(
  parameter int unsigned KW    = 6,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned SW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [SW-1:0] sel,
  input  logic [KW-1:0] key_in,
  output logic [KW-1:0] key_out
);
  logic [KW-1:0] hist_q [DEPTH];
  logic [KW-1:0] hist_d [DEPTH];

  always_comb begin
    hist_d[0] = adv ? key_in : hist_q[0];
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_tap
    always_comb hist_d[g] = adv ? hist_q[g-1] : hist_q[g];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[g] <= '0;
      else        hist_q[g] <= hist_d[g];
    end
  end

  always_comb begin
    if (sel == '0)                         key_out = key_in;
    else if (int'(sel) >= int'(DEPTH))     key_out = hist_q[DEPTH-1];
    else                                   key_out = hist_q[int'(sel) - 1];
  end
endmodule

// File: rtl/fbm_coef.sv
module fbm_coef
  import fbm_pkg::*;
#(
  parameter int unsigned KW = 6,
  parameter int unsigned AW = 4
) (
  input  logic [KW-1:0] key,
  input  logic [KW-1:0] offset,
  input  logic [AW-1:0] amp,
  input  logic          clamp,
  input  logic          invert,
  output weight_t       weight
);
  localparam int unsigned PW = KW + AW + 2;
  localparam logic [KW-1:0] KEY_MID = KW'((1 << (KW - 1)) - 1);
  localparam logic signed [PW-1:0] MIDV  = PW'(WT_MID);
  localparam logic signed [PW-1:0] FULLV = PW'(WT_FULL);

  logic [KW-1:0]          k_eff;
  logic signed [KW+1:0]   diff;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   sum;

  always_comb begin
    if (clamp)       k_eff = KEY_MID;
    else if (invert) k_eff = ~key;
    else             k_eff = key;
    diff = $signed({2'b00, k_eff}) - $signed({2'b00, offset});
    prod = diff * $signed({1'b0, amp});
    sum  = (prod >>> 1) + MIDV;
    if (sum < 0)          weight = '0;
    else if (sum > FULLV) weight = WT_W'(WT_FULL);
    else                  weight = sum[WT_W-1:0];
  end
endmodule

// File: rtl/fbm_blend.sv
module fbm_blend
  import fbm_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  input  weight_t       w,
  output logic [CW-1:0] y
);
  localparam int unsigned XW = CW + WT_W + 1;
  localparam logic [XW-1:0] MAXV = XW'((1 << CW) - 1);

  logic [XW-1:0] acc;
  logic [XW-1:0] sh;

  always_comb begin
    acc = XW'(a) * (XW'(WT_FULL) - XW'(w)) + XW'(b) * XW'(w) + XW'(WT_MID);
    sh  = acc >> WT_BITS;
    y   = (sh > MAXV) ? {CW{1'b1}} : sh[CW-1:0];
  end
endmodule

// File: rtl/fb_soft_mixer.sv
module fb_soft_mixer
  import fbm_pkg::*;
#(
  parameter int unsigned CW    = 8,
  parameter int unsigned NC    = 3,
  parameter int unsigned KW    = 6,
  parameter int unsigned AW    = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [NC*CW-1:0] ana_pix,
  input  logic [NC*CW-1:0] dig_pix,
  input  logic [KW-1:0]   fb_level,
  input  logic [KW-1:0]   cfg_offset,
  input  logic [AW-1:0]   cfg_amp,
  input  logic            cfg_clamp,
  input  logic            cfg_invert,
  input  logic [1:0]      cfg_fb_delay,
  input  logic            cfg_pass_dig,
  input  logic            cfg_pass_ana,
  output logic            out_valid,
  output logic [NC*CW-1:0] out_pix
);
  localparam int unsigned PXW = NC * CW;

  logic [KW-1:0] key_sel;
  weight_t       w_now;

  fbm_key_delay #(.KW(KW), .DEPTH(DEPTH), .SW(2)) u_dly (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .sel(cfg_fb_delay),
    .key_in(fb_level), .key_out(key_sel)
  );

  fbm_coef #(.KW(KW), .AW(AW)) u_coef (
    .key(key_sel), .offset(cfg_offset), .amp(cfg_amp),
    .clamp(cfg_clamp), .invert(cfg_invert), .weight(w_now)
  );

  // stage 1
  logic           s1_valid_q, s1_valid_d;
  logic [PXW-1:0] s1_ana_q, s1_ana_d, s1_dig_q, s1_dig_d;
  weight_t        s1_coef, s1_coef_d;
  logic           s1_pdig_q, s1_pdig_d, s1_pana_q, s1_pana_d;

  always_comb begin
    s1_valid_d = in_valid;
    s1_ana_d   = s1_ana_q;
    s1_dig_d   = s1_dig_q;
    s1_coef_d  = s1_coef;
    s1_pdig_d  = s1_pdig_q;
    s1_pana_d  = s1_pana_q;
    if (in_valid) begin
      s1_ana_d  = ana_pix;
      s1_dig_d  = dig_pix;
      s1_coef_d = w_now;
      s1_pdig_d = cfg_pass_dig;
      s1_pana_d = cfg_pass_ana;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_ana_q   <= '0;
      s1_dig_q   <= '0;
      s1_coef    <= '0;
      s1_pdig_q  <= 1'b0;
      s1_pana_q  <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_ana_q   <= s1_ana_d;
      s1_dig_q   <= s1_dig_d;
      s1_coef    <= s1_coef_d;
      s1_pdig_q  <= s1_pdig_d;
      s1_pana_q  <= s1_pana_d;
    end
  end

  // stage 2
  logic [PXW-1:0] mix_pix;

  for (genvar c = 0; c < NC; c++) begin : g_comp
    fbm_blend #(.CW(CW)) u_blend (
      .a(s1_ana_q[c*CW +: CW]), .b(s1_dig_q[c*CW +: CW]),
      .w(s1_coef), .y(mix_pix[c*CW +: CW])
    );
  end

  logic           out_valid_d;
  logic [PXW-1:0] out_pix_d;

  always_comb begin
    out_valid_d = s1_valid_q;
    out_pix_d   = out_pix;
    if (s1_valid_q) begin
      if (s1_pdig_q)      out_pix_d = s1_dig_q;
      else if (s1_pana_q) out_pix_d = s1_ana_q;
      else                out_pix_d = mix_pix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_pix   <= out_pix_d;
    end
  end
endmodule

// File: rtl/fbm_chk.sv
module fbm_chk
  import fbm_pkg::*;
#(
  parameter int unsigned PXW = 24,
  parameter int unsigned KW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [PXW-1:0] ana_pix,
  input logic [PXW-1:0] dig_pix,
  input logic [KW-1:0]  cfg_offset,
  input logic           cfg_clamp,
  input logic           cfg_pass_dig,
  input logic           cfg_pass_ana,
  input logic           out_valid,
  input logic [PXW-1:0] out_pix,
  input weight_t        s1_coef
);
  localparam logic [KW-1:0] KEY_MID = KW'((1 << (KW - 1)) - 1);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R2
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R2
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R4
  coef_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_coef <= weight_t'(WT_FULL));

  // R5
  clamp_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && $past(in_valid) && $past(cfg_clamp) && $past(cfg_offset) == KEY_MID)
      |-> s1_coef == weight_t'(WT_MID));

  // R8
  pass_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && $past(in_valid, 2) && $past(cfg_pass_dig, 2))
      |-> out_pix == $past(dig_pix, 2));

  // R9
  pass_ana_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && $past(in_valid, 2) && !$past(cfg_pass_dig, 2) && $past(cfg_pass_ana, 2))
      |-> out_pix == $past(ana_pix, 2));
endmodule

bind fb_soft_mixer fbm_chk #(.PXW(NC*CW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ana_pix(ana_pix),
  .dig_pix(dig_pix), .cfg_offset(cfg_offset), .cfg_clamp(cfg_clamp),
  .cfg_pass_dig(cfg_pass_dig), .cfg_pass_ana(cfg_pass_ana),
  .out_valid(out_valid), .out_pix(out_pix), .s1_coef(s1_coef)
);

// File: tb/tb_fb_soft_mixer.sv
module tb_fb_soft_mixer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] ana_pix, dig_pix;
  logic [5:0]  fb_level, cfg_offset;
  logic [3:0]  cfg_amp;
  logic        cfg_clamp, cfg_invert, cfg_pass_dig, cfg_pass_ana;
  logic [1:0]  cfg_fb_delay;
  logic        out_valid;
  logic [23:0] out_pix;

  fb_soft_mixer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ana_pix(ana_pix),
    .dig_pix(dig_pix), .fb_level(fb_level), .cfg_offset(cfg_offset),
    .cfg_amp(cfg_amp), .cfg_clamp(cfg_clamp), .cfg_invert(cfg_invert),
    .cfg_fb_delay(cfg_fb_delay), .cfg_pass_dig(cfg_pass_dig),
    .cfg_pass_ana(cfg_pass_ana), .out_valid(out_valid), .out_pix(out_pix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expectation pipeline
  logic        e1_v, e2_v;
  logic [23:0] e1_p, e2_p;
  string       e1_t, e2_t;
  int          h0, h1;

  function automatic int ref_coef(int key, int off, int amp, bit clamp, bit inv);
    int k, t, m;
    k = inv ? 63 - key : key;
    if (clamp) k = 31;
    t = (k - off) * amp;
    m = (t >= 0) ? t / 2 : -((1 - t) / 2);
    m = m + 16;
    if (m < 0) m = 0;
    if (m > 32) m = 32;
    return m;
  endfunction

  function automatic logic [23:0] ref_mix(logic [23:0] a, logic [23:0] b, int m);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) begin
      int v;
      v = (int'(a[c*8 +: 8]) * (32 - m) + int'(b[c*8 +: 8]) * m + 16) / 32;
      if (v > 255) v = 255;
      r[c*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    e1_v = 0; e2_v = 0; e1_p = '0; e2_p = '0; e1_t = "R2"; e2_t = "R2";
    h0 = 0; h1 = 0;
  endtask

  task automatic step(bit v, logic [23:0] a, logic [23:0] b, int fb, int off,
                      int amp, bit cl, bit inv, int dly, bit pd, bit pa, string tag);
    int key, m;
    logic [23:0] ex;
    @(negedge clk);
    chk(out_valid == e2_v, "R2", {23'd0, out_valid}, {23'd0, e2_v});
    if (e2_v) chk(out_pix == e2_p, e2_t, out_pix, e2_p);
    e2_v = e1_v; e2_p = e1_p; e2_t = e1_t;
    in_valid = v; ana_pix = a; dig_pix = b; fb_level = 6'(fb);
    cfg_offset = 6'(off); cfg_amp = 4'(amp); cfg_clamp = cl; cfg_invert = inv;
    cfg_fb_delay = 2'(dly); cfg_pass_dig = pd; cfg_pass_ana = pa;
    key = (dly == 0) ? fb : (dly == 1) ? h0 : h1;
    m = ref_coef(key, off, amp, cl, inv);
    if (pd) ex = b; else if (pa) ex = a; else ex = ref_mix(a, b, m);
    e1_v = v;
    if (v) begin e1_p = ex; e1_t = tag; h1 = h0; h0 = fb; end
    else   begin e1_p = e2_p; end
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, '0, '0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    clear_model();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", {23'd0, out_valid}, 24'd0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b1;
    in_valid = 0; ana_pix = '0; dig_pix = '0; fb_level = '0; cfg_offset = '0;
    cfg_amp = '0; cfg_clamp = 0; cfg_invert = 0; cfg_fb_delay = '0;
    cfg_pass_dig = 0; cfg_pass_ana = 0;
    clear_model();
    #1 rst_n = 1'b0;
    do_reset();

    // R4 floor on negative side: key one below offset, amp 1 -> weight 15
    step(1, 24'h000000, 24'hFFFFFF, 19, 20, 1, 0, 0, 0, 0, 0, "R4");
    // R4 lower limit -> analog, upper limit -> digital
    step(1, 24'h123456, 24'hABCDEF, 0, 63, 15, 0, 0, 0, 0, 0, "R4");
    step(1, 24'h123456, 24'hABCDEF, 63, 0, 15, 0, 0, 0, 0, 0, "R4");
    // R3 rounding at half weight
    step(1, 24'h000001, 24'h000000, 20, 20, 7, 0, 0, 0, 0, 0, "R3");
    step(1, 24'hFFFFFF, 24'hFFFFFF, 40, 10, 5, 0, 0, 0, 0, 0, "R3");
    // R5 clamp overrides key and polarity
    step(1, 24'h000000, 24'hFFFFFF, 0, 20, 3, 1, 1, 0, 0, 0, "R5");
    step(1, 24'h102030, 24'hF0E0D0, 63, 31, 9, 1, 0, 0, 0, 0, "R5");
    // R6 inversion
    step(1, 24'h000000, 24'hFFFFFF, 0, 0, 15, 0, 1, 0, 0, 0, "R6");
    step(1, 24'h000000, 24'hFFFFFF, 63, 0, 15, 0, 1, 0, 0, 0, "R6");
    // R8 priority, R9 pass analog
    step(1, 24'h111111, 24'h222222, 0, 63, 15, 0, 0, 0, 1, 1, "R8");
    step(1, 24'h333333, 24'h444444, 63, 0, 15, 0, 0, 0, 0, 1, "R9");
    flush();

    // R1 delay history cleared by reset: delay 2 reads key 0
    step(1, 24'h000000, 24'hFFFFFF, 63, 0, 15, 0, 0, 2, 0, 0, "R7");
    step(1, 24'h000000, 24'hFFFFFF, 63, 0, 15, 0, 0, 2, 0, 0, "R7");
    do_reset();
    step(1, 24'h000000, 24'hFFFFFF, 63, 0, 15, 0, 0, 2, 0, 0, "R1");
    step(1, 24'h000000, 24'hFFFFFF, 63, 0, 15, 0, 0, 2, 0, 0, "R1");
    step(1, 24'h000000, 24'hFFFFFF, 63, 0, 15, 0, 0, 2, 0, 0, "R7");
    flush();

    // random segments
    for (int s = 0; s < 24; s++) begin
      int off, amp, dly, mode;
      bit cl, inv, pd, pa;
      string tag;
      off = int'($urandom_range(63)); amp = int'($urandom_range(15));
      dly = int'($urandom_range(3)); mode = s % 6;
      cl = (mode == 2); inv = (mode == 3); pd = (mode == 4);
      pa = (mode == 5) || (mode == 4 && s[0]);
      case (mode)
        0: tag = "R3"; 1: tag = "R7"; 2: tag = "R5";
        3: tag = "R6"; 4: tag = "R8"; default: tag = "R9";
      endcase
      for (int i = 0; i < 60; i++) begin
        bit v;
        v = ($urandom_range(3) != 0);
        step(v, 24'($urandom), 24'($urandom), int'($urandom_range(63)),
             off, amp, cl, inv, dly, pd, pa, tag);
      end
    end
    flush();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule